// File: doc/BRIEF.md
# Eight-Level Rotating-Priority Interrupt Resolver

This block is the request-handling core of an eight-input interrupt controller. It captures requests from eight lines, filters them through a mask register, and drives a single interrupt line when the best eligible request outranks everything already in service. An acknowledge moves the winning level from the pending set into the in-service set. End-of-service commands then release in-service levels, and some of them also rotate the priority order.

Priority is circular. A pointer names the lowest-priority level, and the level just after it is the highest. Commands can move the pointer directly or as a side effect of ending service. A special mask mode replaces nested blocking with a simpler rule: only the levels that are themselves in service are blocked. An automatic-rotation mode releases the level during the acknowledge and makes it the lowest priority, so no command is needed.

Control pins are plain, single-cycle strobes sampled on the rising clock edge. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `irq_prio_core`

## Requirements
- R1: After reset the pending and in-service registers read zero, the mask register reads 0xFF (all masked) and the interrupt line is low. Level 0 is the highest priority and level 7 the lowest.
- R2: A level whose mode bit is 0 (edge) records a request on a low-to-high transition of its input. After that request is acknowledged, it is not recorded again until the input has been low and risen again.
- R3: A level whose mode bit is 1 (level) shows its input value in the pending register one cycle later.
- R4: A mask bit of 1 keeps that level from raising the interrupt, although the level is still recorded as pending. A mask bit of 0 lets it take part. The mask loads from `mask_i` when `mask_we_i` is high.
- R5: Without special mask, the interrupt line is high only when the highest-priority pending unmasked level ranks strictly above every in-service level. `win_lvl_o` then names that level.
- R6: An acknowledge while the interrupt is high sets the winner's in-service bit and clears its pending bit. An acknowledge while the interrupt is low changes nothing.
- R7: Command opcode 1 (nonspecific end) clears the highest-priority in-service bit.
- R8: Command opcode 2 (specific end) clears the in-service bit named by `cmd_lvl_i`.
- R9: Opcodes 3 (rotating nonspecific end) and 4 (rotating specific end) clear the bit in the same way as opcodes 1 and 2. They then make the cleared level the lowest priority, so the next level around the circle becomes the highest.
- R10: Opcode 5 makes `cmd_lvl_i` the lowest priority, and the other levels follow it in circular order. No in-service bit changes.
- R11: With `auto_rot_i` high, an acknowledge clears the winner's pending bit, sets no in-service bit, and makes the winner the lowest priority.
- R12: With `smm_i` high, any pending unmasked level that is not in service raises the interrupt, whatever its rank relative to the in-service levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request lines, one per level |
| lvl_mode_i | input | 8 | Per-level trigger mode: 1 level, 0 edge |
| mask_we_i | input | 1 | Load strobe for the mask register |
| mask_i | input | 8 | New mask value |
| smm_i | input | 1 | Special mask mode enable |
| auto_rot_i | input | 1 | Automatic end with rotation on acknowledge |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command opcode (1..5, others ignored) |
| cmd_lvl_i | input | 3 | Level field of the command |
| ack_i | input | 1 | Acknowledge event |
| irq_o | output | 1 | Interrupt line |
| win_lvl_o | output | 3 | Winning level, meaningful while irq_o is high |
| irr_o | output | 8 | Pending register contents |
| isr_o | output | 8 | In-service register contents |
| imr_o | output | 8 | Mask register contents |

## Verification
The hardest state to reach from the ports is a moved priority pointer combined with several levels pending or in service on both sides of it. Only such a mix shows whether rank comparisons wrap correctly. The stimulus builds it in steps. It acknowledges a level and ends it with a rotating command, then raises two requests on either side of the new pointer in the same cycle, so that only correct circular ordering picks the expected winner. Nested service is reached the same way: one level is acknowledged first, and then a lower and a higher request arrive.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int NLVL = 8;
  localparam int LW   = $clog2(NLVL);

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_END_NS  = 3'd1,
    OP_END_SP  = 3'd2,
    OP_ROT_NS  = 3'd3,
    OP_ROT_SP  = 3'd4,
    OP_SET_LOW = 3'd5
  } op_e;

  typedef struct packed {
    logic          hit;
    logic [LW-1:0] lvl;
    logic [LW-1:0] rank;
  } pick_t;
endpackage

// File: rtl/irqp_req.sv
module irqp_req
  import irqp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] req_i,
  input  logic [NLVL-1:0] lvl_mode_i,
  input  logic [NLVL-1:0] clr_i,
  output logic [NLVL-1:0] irr_o
);
  logic [NLVL-1:0] req_q, irr_q, irr_d;

  // edge levels hold until acknowledged; level levels follow the input
  assign irr_d = (lvl_mode_i & req_i)
               | (~lvl_mode_i & ((irr_q & ~clr_i) | (req_i & ~req_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      irr_q <= '0;
    end else begin
      req_q <= req_i;
      irr_q <= irr_d;
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/irqp_pick.sv
module irqp_pick
  import irqp_pkg::*;
(
  input  logic [NLVL-1:0] vec_i,
  input  logic [LW-1:0]   low_i,
  output pick_t           pick_o
);
  logic [LW-1:0] idx;

  always_comb begin
    pick_o = '0;
    idx    = '0;
    // walk from lowest rank upward so the highest-ranked hit is kept last
    for (int k = NLVL - 1; k >= 0; k--) begin
      idx = low_i + LW'(k + 1);
      if (vec_i[idx]) begin
        pick_o.hit  = 1'b1;
        pick_o.lvl  = idx;
        pick_o.rank = LW'(k);
      end
    end
  end
endmodule

// File: rtl/irqp_svc.sv
module irqp_svc
  import irqp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_fire_i,
  input  logic [LW-1:0]   win_i,
  input  logic            auto_rot_i,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_op_i,
  input  logic [LW-1:0]   cmd_lvl_i,
  input  pick_t           top_is_i,
  output logic [NLVL-1:0] isr_o,
  output logic [LW-1:0]   low_o
);
  logic [NLVL-1:0] isr_q, isr_d;
  logic [LW-1:0]   low_q, low_d;

  always_comb begin
    isr_d = isr_q;
    low_d = low_q;
    if (ack_fire_i) begin
      if (auto_rot_i) low_d = win_i;
      else            isr_d[win_i] = 1'b1;
    end
    if (cmd_valid_i) begin
      case (op_e'(cmd_op_i))
        OP_END_NS:  if (top_is_i.hit) isr_d[top_is_i.lvl] = 1'b0;
        OP_END_SP:  isr_d[cmd_lvl_i] = 1'b0;
        OP_ROT_NS:  if (top_is_i.hit) begin
                      isr_d[top_is_i.lvl] = 1'b0;
                      low_d = top_is_i.lvl;
                    end
        OP_ROT_SP:  begin
                      isr_d[cmd_lvl_i] = 1'b0;
                      low_d = cmd_lvl_i;
                    end
        OP_SET_LOW: low_d = cmd_lvl_i;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      low_q <= LW'(NLVL - 1);
    end else begin
      isr_q <= isr_d;
      low_q <= low_d;
    end
  end

  assign isr_o = isr_q;
  assign low_o = low_q;
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irqp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] req_i,
  input  logic [NLVL-1:0] lvl_mode_i,
  input  logic            mask_we_i,
  input  logic [NLVL-1:0] mask_i,
  input  logic            smm_i,
  input  logic            auto_rot_i,
  input  logic            cmd_valid_i,
  input  logic [2:0]      cmd_op_i,
  input  logic [LW-1:0]   cmd_lvl_i,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [LW-1:0]   win_lvl_o,
  output logic [NLVL-1:0] irr_o,
  output logic [NLVL-1:0] isr_o,
  output logic [NLVL-1:0] imr_o
);
  logic [NLVL-1:0] imr_q, irr, isr, pend, cand, clr;
  logic [LW-1:0]   low;
  pick_t           p_req, p_isr;
  logic            irq, ack_fire;

  always_ff @(posedge clk) begin
    if (!rst_n)         imr_q <= '1;
    else if (mask_we_i) imr_q <= mask_i;
  end

  irqp_req u_req (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .lvl_mode_i(lvl_mode_i),
    .clr_i(clr), .irr_o(irr)
  );

  assign pend = irr & ~imr_q;
  assign cand = smm_i ? (pend & ~isr) : pend;

  irqp_pick u_pick_req (.vec_i(cand), .low_i(low), .pick_o(p_req));
  irqp_pick u_pick_isr (.vec_i(isr),  .low_i(low), .pick_o(p_isr));

  assign irq      = p_req.hit && (smm_i || !p_isr.hit || (p_req.rank < p_isr.rank));
  assign ack_fire = ack_i && irq;
  assign clr      = ack_fire ? (NLVL'(1) << p_req.lvl) : '0;

  irqp_svc u_svc (
    .clk(clk), .rst_n(rst_n), .ack_fire_i(ack_fire), .win_i(p_req.lvl),
    .auto_rot_i(auto_rot_i), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_lvl_i(cmd_lvl_i), .top_is_i(p_isr), .isr_o(isr), .low_o(low)
  );

  assign irq_o     = irq;
  assign win_lvl_o = p_req.lvl;
  assign irr_o     = irr;
  assign isr_o     = isr;
  assign imr_o     = imr_q;
endmodule

// File: rtl/irqp_chk.sv
module irqp_chk
  import irqp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            ack_i,
  input logic            cmd_valid_i,
  input logic [2:0]      cmd_op_i,
  input logic [LW-1:0]   cmd_lvl_i,
  input logic            auto_rot_i,
  input logic            smm_i,
  input logic            irq_o,
  input logic [LW-1:0]   win_lvl_o,
  input logic [NLVL-1:0] irr_o,
  input logic [NLVL-1:0] isr_o,
  input logic [NLVL-1:0] imr_o
);
  logic [LW-1:0] win_q, lvl_q;

  always_ff @(posedge clk) begin
    win_q <= win_lvl_o;
    lvl_q <= cmd_lvl_i;
  end

  // R6
  ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !auto_rot_i && !cmd_valid_i) |=> isr_o[win_q]);

  // R4
  winner_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !imr_o[win_lvl_o]);

  // R5
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irr_o[win_lvl_o]);

  // R12
  smm_not_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_i && irq_o) |-> !isr_o[win_lvl_o]);

  // R8
  specific_end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == 3'd2 && !ack_i) |=> !isr_o[lvl_q]);

  // R11
  auto_rot_keeps_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && auto_rot_i && !cmd_valid_i) |=> (isr_o == $past(isr_o)));
endmodule

bind irq_prio_core irqp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .cmd_valid_i(cmd_valid_i),
  .cmd_op_i(cmd_op_i), .cmd_lvl_i(cmd_lvl_i), .auto_rot_i(auto_rot_i),
  .smm_i(smm_i), .irq_o(irq_o), .win_lvl_o(win_lvl_o), .irr_o(irr_o),
  .isr_o(isr_o), .imr_o(imr_o)
);

// File: tb/sim_irq_prio_core.sv
module sim_irq_prio_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mode = '0, mask_v = '0;
  logic       mask_we = 1'b0, smm = 1'b0, auto_rot = 1'b0;
  logic       cmd_valid = 1'b0, ack = 1'b0;
  logic [2:0] cmd_op = '0, cmd_lvl = '0;
  logic       irq;
  logic [2:0] win;
  logic [7:0] irr, isr, imr;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_core u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lvl_mode_i(mode),
    .mask_we_i(mask_we), .mask_i(mask_v), .smm_i(smm), .auto_rot_i(auto_rot),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_lvl_i(cmd_lvl),
    .ack_i(ack), .irq_o(irq), .win_lvl_o(win), .irr_o(irr), .isr_o(isr),
    .imr_o(imr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rise(input logic [7:0] m);
    req = req | m; @(negedge clk);
  endtask
  task automatic fall(input logic [7:0] m);
    req = req & ~m; @(negedge clk);
  endtask
  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask
  task automatic cmd(input logic [2:0] op, input logic [2:0] lvl);
    cmd_valid = 1'b1; cmd_op = op; cmd_lvl = lvl;
    @(negedge clk); cmd_valid = 1'b0;
  endtask
  task automatic set_mask(input logic [7:0] m);
    mask_we = 1'b1; mask_v = m; @(negedge clk); mask_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irr", irr, 0); chk("R1 isr", isr, 0);
    chk("R1 imr", imr, 8'hFF); chk("R1 irq", irq, 0);
    set_mask(8'h00);
    rise(8'h81);
    chk("R1 level0 highest", win, 0);
    do_ack(); cmd(3'd1, 0); do_ack(); cmd(3'd1, 0); fall(8'h81);
    chk("R1 drained", {isr, irr}, 0);
  endtask

  task automatic t_edge();
    rise(8'h08);
    chk("R2 captured", irr, 8'h08); chk("R2 irq", irq, 1); chk("R2 win", win, 3);
    do_ack();
    chk("R6 isr set", isr, 8'h08); chk("R6 irr cleared", irr, 0);
    repeat (2) @(negedge clk);
    chk("R2 held high no recapture", irr, 0);
    cmd(3'd1, 0);
    chk("R7 single end", isr, 0); chk("R2 still idle", irq, 0);
    fall(8'h08); rise(8'h08);
    chk("R2 recapture after low", irr, 8'h08);
    do_ack(); cmd(3'd1, 0); fall(8'h08);
  endtask

  task automatic t_level();
    mode = 8'h20;
    rise(8'h20); chk("R3 follows high", irr, 8'h20);
    fall(8'h20); chk("R3 follows low", irr, 0);
    mode = 8'h00; @(negedge clk);
  endtask

  task automatic t_mask();
    set_mask(8'h04);
    rise(8'h04);
    chk("R4 recorded", irr, 8'h04); chk("R4 masked no irq", irq, 0);
    set_mask(8'h00);
    chk("R4 unmasked irq", irq, 1); chk("R4 win", win, 2);
    do_ack(); cmd(3'd1, 0); fall(8'h04);
  endtask

  task automatic t_nest();
    do_ack();
    chk("R6 idle ack ignored", {isr, irr}, 0);
    rise(8'h10); do_ack();
    rise(8'h40);
    chk("R5 lower blocked", irq, 0);
    rise(8'h02);
    chk("R5 higher irq", irq, 1); chk("R5 higher win", win, 1);
    do_ack(); chk("R6 nested isr", isr, 8'h12);
    cmd(3'd1, 0); chk("R7 clears highest", isr, 8'h10); chk("R5 still blocked", irq, 0);
    cmd(3'd2, 4); chk("R8 specific", isr, 0); chk("R8 pending wins", win, 6);
    do_ack(); cmd(3'd2, 6); fall(8'h52);
  endtask

  task automatic t_rot();
    rise(8'h10); do_ack();
    cmd(3'd3, 0); chk("R9 rot ns clears", isr, 0);
    fall(8'h10);
    rise(8'h28);
    chk("R9 rotated winner", win, 5);
    do_ack(); chk("R9 isr5", isr, 8'h20);
    cmd(3'd4, 5); chk("R9 rot sp clears", isr, 0); chk("R9 after rot sp", win, 3);
    do_ack(); cmd(3'd1, 0); fall(8'h28);
    cmd(3'd5, 7);
  endtask

  task automatic t_setprio();
    cmd(3'd5, 2); chk("R10 isr untouched", isr, 0);
    rise(8'h0D);
    chk("R10 highest after 2", win, 3);
    do_ack(); chk("R10 lower blocked", irq, 0);
    cmd(3'd2, 3); chk("R10 wrap order", win, 0);
    do_ack(); cmd(3'd2, 0);
    chk("R10 lowest last", win, 2);
    do_ack(); cmd(3'd2, 2);
    chk("R10 drained", irq, 0);
    fall(8'h0D); cmd(3'd5, 7);
  endtask

  task automatic t_auto();
    auto_rot = 1'b1;
    rise(8'h01); do_ack();
    chk("R11 no isr", isr, 0); chk("R11 irr cleared", irr, 0);
    fall(8'h01);
    rise(8'h03);
    chk("R11 rotated win", win, 1);
    do_ack(); chk("R11 next", win, 0); chk("R11 irq", irq, 1);
    do_ack(); chk("R11 isr empty", isr, 0);
    fall(8'h03); auto_rot = 1'b0; cmd(3'd5, 7);
  endtask

  task automatic t_smm();
    smm = 1'b1;
    rise(8'h04); do_ack();
    rise(8'h20);
    chk("R12 lower allowed", irq, 1); chk("R12 win", win, 5);
    do_ack(); chk("R12 isr", isr, 8'h24);
    fall(8'h04); rise(8'h04);
    chk("R12 pending", irr, 8'h04); chk("R12 in-service blocked", irq, 0);
    cmd(3'd2, 2); chk("R12 released", win, 2); chk("R12 irq", irq, 1);
    cmd(3'd2, 5); do_ack(); cmd(3'd2, 2); fall(8'h24);
    smm = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_edge(); t_level(); t_mask(); t_nest();
    t_rot(); t_setprio(); t_auto(); t_smm();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule